// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor Core

This core runs programs built from one instruction only: subtract one memory word from another, store the difference, and branch if the difference is zero or negative. An instruction has no opcode. It is three consecutive words: the address of the subtrahend (A), the address of the minuend (B), and a branch target (C). Program and data share one single-port word memory outside the core. The core reaches that memory through an address, write data, write enable and synchronous read data port. A read has one cycle of latency.

Every instruction takes exactly seven clock cycles. A phase counter sequences the cycles:
- fetch the three instruction words;
- read the two operands;
- write the difference back to B;
- choose the next program counter.

Address B equal to all ones is reserved as the output location. An instruction aimed there does not write memory. It raises an output strobe for one cycle, with the difference on a data port. Execution starts at address 0 after a synchronous reset.

Top module: `subleq_core`

## Requirements
- R1: In phases 0, 1 and 2 of an instruction, the memory address is PC, PC+1 and PC+2. The words returned are taken as A, B and C.
- R2: An instruction lasts exactly seven cycles. Phases are numbered 0 to 6 and phase 6 wraps to 0. A memory write or output strobe occurs only in phase 6, and at most once per instruction.
- R3: The memory address is A in phase 3 and B in phase 4. The words read there are the subtrahend and the minuend.
- R4: In phase 6, when B is not 16'hFFFF, the core writes Mem[B] - Mem[A] (modulo 2^16) to address B with the write enable high.
- R5: When the difference has its sign bit set or is zero, the next instruction is fetched from C.
- R6: When the difference is strictly positive, the next instruction is fetched from PC+3.
- R7: When B is 16'hFFFF, phase 6 asserts no write. Instead the output strobe is high for that one cycle, and the output data carries the difference. Reads of that address return whatever the memory supplies. The branch rule still applies.
- R8: While reset is high, the write enable and the output strobe are low and the address is 0. The first cycle after reset is phase 0 with PC 0.
- R9: Read data presented on the cycle after an address is captured as that address's word. Memory contents outside the instruction's own B word are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 16 | Write data (difference) |
| mem_we | output | 1 | Write enable, phase 6 only |
| mem_rdata | input | 16 | Read data, one cycle after address |
| out_valid | output | 1 | Output strobe for writes to 16'hFFFF |
| out_data | output | 16 | Output word, valid with out_valid |

## Verification
A wrong phase count or a corrupted operand register shows on the memory address within the same instruction. It appears either as a fetch address off the PC sequence or as an operand address that differs from the fetched A or B. A wrong subtraction or a wrong B register shows in phase 6 as a bad write address or value. A wrong branch decision shows seven cycles later as the next phase-0 address. The bench follows the address bus every cycle, so any fault becomes visible within one instruction of its cause.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    localparam int unsigned PH_W     = 3;
    localparam int unsigned INSTR_WD = 3;

    typedef enum logic [PH_W-1:0] {
        PH_ADDR0 = 3'd0,
        PH_ADDR1 = 3'd1,
        PH_ADDR2 = 3'd2,
        PH_OPA   = 3'd3,
        PH_OPB   = 3'd4,
        PH_LOAD  = 3'd5,
        PH_EXEC  = 3'd6
    } phase_e;

endpackage

// File: rtl/subleq_phase_seq.sv
module subleq_phase_seq
    import subleq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    typedef struct packed {
        phase_e ph;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_EXEC) begin
            s_d.ph = PH_ADDR0;
        end else begin
            s_d.ph = phase_e'(s_q.ph + 3'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph <= PH_ADDR0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
endmodule

// File: rtl/subleq_alu.sv
module subleq_alu #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] minuend,
    input  logic [DW-1:0] subtrahend,
    output logic [DW-1:0] diff,
    output logic          le_zero
);
    always_comb begin
        diff    = minuend - subtrahend;
        le_zero = diff[DW-1] | (diff == '0);
    end
endmodule

// File: rtl/subleq_next_pc.sv
module subleq_next_pc
    import subleq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] target,
    input  logic          take,
    output logic [DW-1:0] next_pc
);
    localparam logic [DW-1:0] STEP = DW'(INSTR_WD);

    always_comb begin
        if (take) begin
            next_pc = target;
        end else begin
            next_pc = pc + STEP;
        end
    end
endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam logic [DW-1:0] OUT_LOC = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] a_loc;
        logic [DW-1:0] b_loc;
        logic [DW-1:0] c_loc;
        logic [DW-1:0] a_val;
        logic [DW-1:0] b_val;
    } regs_t;

    regs_t         r_d, r_q;
    phase_e        phase;
    logic [DW-1:0] diff;
    logic          le0;
    logic [DW-1:0] npc;
    logic          is_out;

    subleq_phase_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    subleq_alu #(.DW(DW)) u_alu (
        .minuend    (r_q.b_val),
        .subtrahend (r_q.a_val),
        .diff       (diff),
        .le_zero    (le0)
    );

    subleq_next_pc #(.DW(DW)) u_npc (
        .pc      (r_q.pc),
        .target  (r_q.c_loc),
        .take    (le0),
        .next_pc (npc)
    );

    always_comb begin
        r_d = r_q;
        unique case (phase)
            PH_ADDR1: r_d.a_loc = mem_rdata;
            PH_ADDR2: r_d.b_loc = mem_rdata;
            PH_OPA:   r_d.c_loc = mem_rdata;
            PH_OPB:   r_d.a_val = mem_rdata;
            PH_LOAD:  r_d.b_val = mem_rdata;
            PH_EXEC:  r_d.pc    = npc;
            default:  r_d = r_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (phase)
            PH_ADDR0, PH_ADDR1, PH_ADDR2:
                mem_addr = r_q.pc + {{(DW-PH_W){1'b0}}, phase};
            PH_OPA:  mem_addr = r_q.a_loc;
            default: mem_addr = r_q.b_loc;
        endcase
    end

    assign is_out    = (r_q.b_loc == OUT_LOC);
    assign mem_we    = (phase == PH_EXEC) && !is_out;
    assign out_valid = (phase == PH_EXEC) && is_out;
    assign mem_wdata = diff;
    assign out_data  = diff;
endmodule

// File: rtl/subleq_core_chk.sv
module subleq_core_chk
    import subleq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    phase,
    input logic [DW-1:0] mem_addr,
    input logic          mem_we,
    input logic          out_valid,
    input logic          le0,
    input logic [DW-1:0] br,
    input logic [DW-1:0] pc
);
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd6) |=> (phase == 3'd0)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd6) |=> (phase == $past(phase) + 3'd1)); // R2
    AST_WRITE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        (mem_we || out_valid) |-> (phase == 3'd6)); // R2
    AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 || phase == 3'd2) |-> (mem_addr == $past(mem_addr) + DW'(1))); // R1
    AST_NO_WRITE_OUTLOC: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr != {DW{1'b1}})); // R7
    AST_NEXT_PC: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd6) |=> (mem_addr == ($past(le0) ? $past(br) : $past(pc) + DW'(3)))); // R5
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && phase == 3'd0)); // R8
endmodule

bind subleq_core subleq_core_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .le0       (le0),
    .br        (r_q.c_loc),
    .pc        (r_q.pc)
);

// File: tb/subleq_core_bench.sv
module subleq_core_bench;
    typedef struct {
        logic [15:0] pc;
        logic [15:0] a;
        logic [15:0] b;
        logic        is_out;
        logic [15:0] waddr;
        logic [15:0] wdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, out_data;
    logic        mem_we, out_valid;

    logic [15:0] mem [0:63];
    exp_t        q[$];
    exp_t        cur;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int          outs = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    subleq_core u_subleq_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] init_word(int i);
        case (i)
            0: return 16'd40;  1: return 16'd41;   2: return 16'd3;
            3: return 16'd42;  4: return 16'd43;   5: return 16'd9;
            6: return 16'd40;  7: return 16'd41;   8: return 16'd6;
            9: return 16'd44; 10: return 16'hFFFF; 11: return 16'd12;
            12: return 16'd45; 13: return 16'd45; 14: return 16'd12;
            40: return 16'd3;  41: return 16'd5;   42: return 16'd7;
            43: return 16'd4;  44: return 16'hFFFB; 45: return 16'd9;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
            mem_rdata <= 16'd0;
        end else begin
            if (mem_we && mem_addr < 16'd64) mem[mem_addr[5:0]] <= mem_wdata;
            mem_rdata <= (mem_addr < 16'd64) ? mem[mem_addr[5:0]] : 16'd0;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push_instr(input logic [15:0] pc, input logic [15:0] a, input logic [15:0] b,
                              input logic is_out, input logic [15:0] waddr, input logic [15:0] wdata);
        exp_t e;
        e.pc = pc; e.a = a; e.b = b; e.is_out = is_out; e.waddr = waddr; e.wdata = wdata;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ph;
            ph = cyc % 7;
            if (ph == 0 && q.size() > 0) cur = q.pop_front();
            case (ph)
                0: chk("R1 fetch PC (R5/R6 branch)", mem_addr, cur.pc);
                1: chk("R1 fetch PC+1", mem_addr, cur.pc + 16'd1);
                2: chk("R1 fetch PC+2", mem_addr, cur.pc + 16'd2);
                3: chk("R3 operand A address", mem_addr, cur.a);
                4: chk("R3 operand B address", mem_addr, cur.b);
                default: ;
            endcase
            if (ph != 6) begin
                chk("R2 no write outside phase 6", {15'd0, mem_we | out_valid}, 16'd0);
            end else if (cur.is_out) begin
                outs++;
                chk("R7 output strobe", {15'd0, out_valid}, 16'd1);
                chk("R7 no memory write", {15'd0, mem_we}, 16'd0);
                chk("R7 output data", out_data, cur.wdata);
            end else begin
                chk("R4 write enable", {15'd0, mem_we}, 16'd1);
                chk("R4 write address", mem_addr, cur.waddr);
                chk("R4 write data", mem_wdata, cur.wdata);
            end
            cyc++;
        end
    end

    initial begin
        push_instr(16'd0,  16'd40, 16'd41,   1'b0, 16'd41, 16'd2);      // positive: R6
        push_instr(16'd3,  16'd42, 16'd43,   1'b0, 16'd43, 16'hFFFD);   // negative: R5
        push_instr(16'd9,  16'd44, 16'hFFFF, 1'b1, 16'hFFFF, 16'd5);    // output: R7
        push_instr(16'd12, 16'd45, 16'd45,   1'b0, 16'd45, 16'd0);      // zero: R5
        push_instr(16'd12, 16'd45, 16'd45,   1'b0, 16'd45, 16'd0);
        push_instr(16'd12, 16'd45, 16'd45,   1'b0, 16'd45, 16'd0);
        repeat (3) @(negedge clk);
        chk("R8 reset address", mem_addr, 16'd0);
        chk("R8 reset write enable", {15'd0, mem_we}, 16'd0);
        chk("R8 reset strobe", {15'd0, out_valid}, 16'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        wait (cyc == 42);
        @(posedge clk);
        #1;
        done = 1'b1;
        chk("R4 final Mem[41]", mem[41], 16'd2);
        chk("R4 final Mem[43]", mem[43], 16'hFFFD);
        chk("R4 final Mem[45]", mem[45], 16'd0);
        chk("R9 Mem[40] untouched", mem[40], 16'd3);
        chk("R9 Mem[44] untouched", mem[44], 16'hFFFB);
        chk("R9 Mem[42] untouched", mem[42], 16'd7);
        chk("R7 output count", 16'(outs), 16'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule